// File: doc/BRIEF.md
# Trigger Phase-Aligned Two-Lane Capture

This block records a burst from a converter stream that carries two samples per fabric clock, an even-slot sample and an odd-slot sample, and starts the record at an external trigger with one-sample precision rather than two. The trigger arrives as two single-rate bits per fabric clock. One was captured on the rising edge of the fabric clock and stands for the even slot. The other was captured on the falling edge and stands for the odd slot. From these two bits the block decides in which slot the trigger edge landed.

Software first arms the block with a delay trim, counted in samples, and a record length, counted in output pairs. The trim cancels the extra delay of the trigger cable. After the first trigger rising edge, the block waits out the trim. It then emits the requested number of sample pairs, re-paired where needed so that the first sample of the first pair is the trigger sample plus the trim. When the record is done the block goes idle and ignores the trigger until it is armed again. A trigger that is not locked to the sample clock can still move the start point by one sample between acquisitions. The block accepts that and has no circuit to correct it.

Top module: `trig_phase_capture`

## Requirements
- R1: After reset `out_valid` and `out_first` are 0. A trigger that is already high when reset ends does not count as an edge: the odd-slot bit must be seen low first.
- R2: A high `arm` while idle or armed puts the block in the armed state and latches `trim` and `rec_len`. Changes to those inputs after that have no effect on the record.
- R3: A trigger edge is detected in a cycle where the previous cycle's odd-slot bit was 0 and either current bit is 1. If the even-slot bit (`trig_rise`) is 1, the trigger sample is the even slot of that cycle. If only `trig_fall` is 1, it is the odd slot.
- R4: When the start sample falls in an even slot, each output pair is the even and odd samples of one input cycle, with the even sample on `out_even`.
- R5: When the start sample falls in an odd slot, each output pair is the odd sample of one input cycle on `out_even` and the even sample of the next input cycle on `out_odd`.
- R6: The first output sample is the trigger sample plus `trim` (samples, 0 to 63). Bit 0 of phase-plus-trim picks the slot and the upper bits delay the start in whole cycles.
- R7: If the trigger is in input cycle n, the first valid pair appears at the outputs after the clock edge that ends cycle n + ((phase + trim) >> 1) + 1, where phase is 0 for even and 1 for odd.
- R8: A record is exactly `rec_len` consecutive valid pairs, or one pair when `rec_len` is 0. The samples are contiguous, and `out_first` is high on the first pair only.
- R9: Trigger edges during the trim wait, during the record, or after the record ends (without a new arm) start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, half the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm request; latches trim and length |
| trim | input | TRIM_W (6) | Trigger-to-data delay in samples |
| rec_len | input | LEN_W (10) | Record length in output pairs |
| trig_rise | input | 1 | Trigger bit captured on the rising edge (even slot) |
| trig_fall | input | 1 | Trigger bit captured on the falling edge (odd slot) |
| samp_even | input | DATA_W (12) | Even-slot sample of this cycle |
| samp_odd | input | DATA_W (12) | Odd-slot sample of this cycle |
| out_valid | output | 1 | Output pair is part of the record |
| out_first | output | 1 | Marks the first pair of the record |
| out_even | output | DATA_W (12) | Earlier sample of the aligned pair |
| out_odd | output | DATA_W (12) | Later sample of the aligned pair |

## Verification
The assertions assume that `trig_fall` and `trig_rise` are clean single-rate bits that change only between clock edges. They also assume that after reset the trigger settles low before the first real edge; otherwise the detector's history is meaningless. The stimulus honours this. Every input is driven on the falling edge of the clock. The trigger is low whenever the block is armed, except in the cycle that carries the intended edge. The sample lanes carry a running sample index, so any misalignment appears as a wrong value. The later trigger pulses during and after a record are made on purpose, to show that they are ignored.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_EMIT  = 2'd3
  } tpc_state_t;
endpackage

// File: rtl/tpc_phase_det.sv
// Trigger edge and slot detector working on the two half-cycle captures.
module tpc_phase_det (
  input  logic clk,
  input  logic rst,
  input  logic trig_rise,
  input  logic trig_fall,
  output logic evt,
  output logic phase_odd
);
  // Last trigger level seen (odd-slot capture). Reset high so a level
  // that is already asserted does not look like an edge.
  logic last_lvl_q;

  always_ff @(posedge clk) begin
    if (rst) last_lvl_q <= 1'b1;
    else     last_lvl_q <= trig_fall;
  end

  always_comb begin
    evt       = !last_lvl_q && (trig_rise || trig_fall);
    phase_odd = !trig_rise;
  end

  // R3: an edge in the odd slot needs the even-slot capture low
  p_odd_means_late_r3: assert property (@(posedge clk) disable iff (rst)
    (evt && phase_odd) |-> (trig_fall && !trig_rise));
endmodule

// File: rtl/tpc_seq.sv
// Arm / wait / delay / emit sequencer.
module tpc_seq
  import tpc_pkg::*;
#(
  parameter int TRIM_W = 6,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [TRIM_W-1:0] trim,
  input  logic [LEN_W-1:0]  rec_len,
  input  logic              evt,
  input  logic              phase_odd,
  output logic              emit,
  output logic              emit_first,
  output logic              slot_odd
);
  localparam int TOT_W = TRIM_W + 1;

  tpc_state_t        state_q;
  logic [TRIM_W-1:0] trim_q;
  logic [LEN_W-1:0]  len_q;
  logic [TRIM_W-1:0] wait_q;
  logic [LEN_W-1:0]  left_q;
  logic              slot_q;
  logic              first_q;
  logic [TOT_W-1:0]  total;

  assign total = {1'b0, trim_q} + {{TRIM_W{1'b0}}, phase_odd};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      trim_q  <= '0;
      len_q   <= '0;
      wait_q  <= '0;
      left_q  <= '0;
      slot_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_ARMED: begin
          if (arm) begin
            trim_q  <= trim;
            len_q   <= rec_len;
            state_q <= ST_ARMED;
          end else if (state_q == ST_ARMED && evt) begin
            slot_q  <= total[0];
            wait_q  <= total[TOT_W-1:1];
            left_q  <= (len_q == '0) ? LEN_W'(1) : len_q;
            first_q <= 1'b1;
            state_q <= (total[TOT_W-1:1] == '0) ? ST_EMIT : ST_DELAY;
          end
        end
        ST_DELAY: begin
          wait_q <= wait_q - 1'b1;
          if (wait_q == TRIM_W'(1)) state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          first_q <= 1'b0;
          left_q  <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    emit       = (state_q == ST_EMIT);
    emit_first = first_q;
    slot_odd   = slot_q;
  end

  // R7: the delay counter is never zero while waiting
  p_wait_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY) |-> (wait_q != '0));
  // R8: remaining count stays within the latched length
  p_left_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EMIT) |-> (left_q != '0 && (len_q == '0 || left_q <= len_q)));
  // R9: the last pair returns the block to idle
  p_last_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EMIT && left_q == LEN_W'(1)) |=> (state_q == ST_IDLE));
  // R9: a running record never falls back to waiting for a trigger
  p_no_rearm_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY || state_q == ST_EMIT) |=> (state_q != ST_ARMED));
endmodule

// File: rtl/tpc_align.sv
// Re-pairs the two sample lanes according to the start slot.
module tpc_align #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] samp_even,
  input  logic [DATA_W-1:0] samp_odd,
  input  logic              emit,
  input  logic              emit_first,
  input  logic              slot_odd,
  output logic              out_valid,
  output logic              out_first,
  output logic [DATA_W-1:0] out_even,
  output logic [DATA_W-1:0] out_odd
);
  localparam int LANES = 2;

  logic [DATA_W-1:0] held_q [LANES];
  logic [DATA_W-1:0] lane_in [LANES];

  assign lane_in[0] = samp_even;
  assign lane_in[1] = samp_odd;

  for (genvar g = 0; g < LANES; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) held_q[g] <= '0;
      else     held_q[g] <= lane_in[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_even  <= '0;
      out_odd   <= '0;
    end else begin
      out_valid <= emit;
      out_first <= emit && emit_first;
      if (emit) begin
        if (slot_odd) begin
          out_even <= held_q[1];
          out_odd  <= samp_even;
        end else begin
          out_even <= held_q[0];
          out_odd  <= held_q[1];
        end
      end
    end
  end

  // R8: a marker is only ever on a valid pair
  p_first_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_valid);
  // R8: every burst of valid output opens with the marker
  p_burst_opens_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_first);
  // R8: the marker never lasts two cycles
  p_first_single_r8: assert property (@(posedge clk) disable iff (rst)
    out_first |=> !out_first);
endmodule

// File: rtl/trig_phase_capture.sv
module trig_phase_capture #(
  parameter int DATA_W = 12,
  parameter int TRIM_W = 6,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [TRIM_W-1:0] trim,
  input  logic [LEN_W-1:0]  rec_len,
  input  logic              trig_rise,
  input  logic              trig_fall,
  input  logic [DATA_W-1:0] samp_even,
  input  logic [DATA_W-1:0] samp_odd,
  output logic              out_valid,
  output logic              out_first,
  output logic [DATA_W-1:0] out_even,
  output logic [DATA_W-1:0] out_odd
);
  logic evt, phase_odd, emit, emit_first, slot_odd;

  tpc_phase_det u_det (
    .clk       (clk),
    .rst       (rst),
    .trig_rise (trig_rise),
    .trig_fall (trig_fall),
    .evt       (evt),
    .phase_odd (phase_odd)
  );

  tpc_seq #(.TRIM_W(TRIM_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .trim       (trim),
    .rec_len    (rec_len),
    .evt        (evt),
    .phase_odd  (phase_odd),
    .emit       (emit),
    .emit_first (emit_first),
    .slot_odd   (slot_odd)
  );

  tpc_align #(.DATA_W(DATA_W)) u_align (
    .clk        (clk),
    .rst        (rst),
    .samp_even  (samp_even),
    .samp_odd   (samp_odd),
    .emit       (emit),
    .emit_first (emit_first),
    .slot_odd   (slot_odd),
    .out_valid  (out_valid),
    .out_first  (out_first),
    .out_even   (out_even),
    .out_odd    (out_odd)
  );

  // R1: nothing comes out in the cycle right after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/trig_phase_capture_bench.sv
module trig_phase_capture_bench;
  localparam int DW = 12;
  localparam int TW = 6;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arm = 1'b0;
  logic [TW-1:0] trim = '0;
  logic [LW-1:0] rec_len = '0;
  logic          trig_rise = 1'b0;
  logic          trig_fall = 1'b0;
  logic [DW-1:0] samp_even = '0;
  logic [DW-1:0] samp_odd = '0;
  logic          out_valid, out_first;
  logic [DW-1:0] out_even, out_odd;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  trig_phase_capture #(.DATA_W(DW), .TRIM_W(TW), .LEN_W(LW)) u_trig_phase_capture (
    .clk(clk), .rst(rst), .arm(arm), .trim(trim), .rec_len(rec_len),
    .trig_rise(trig_rise), .trig_fall(trig_fall),
    .samp_even(samp_even), .samp_odd(samp_odd),
    .out_valid(out_valid), .out_first(out_first),
    .out_even(out_even), .out_odd(out_odd)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Drive one cycle of samples (index 2c, 2c+1), clock it, sample at negedge.
  task automatic tick();
    samp_even = DW'(2 * cyc);
    samp_odd  = DW'(2 * cyc + 1);
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic set_trig(input logic r, input logic f);
    trig_rise = r;
    trig_fall = f;
  endtask

  // pat: 0 = edge in even slot, 1 = edge in odd slot, 2 = even-only capture
  task automatic run_capture(input int pat, input int tr, input int len, input int pre);
    int ph, total, off, elen, tc, s0, last_k;
    string dtag;
    ph = (pat == 1) ? 1 : 0;
    set_trig(1'b0, 1'b0);
    arm = 1'b1; trim = TW'(tr); rec_len = LW'(len);
    tick();
    arm = 1'b0;
    trim = ~TW'(tr);           // R2: changes after arming must not matter
    rec_len = LW'(len) ^ LW'(5);
    for (int i = 0; i < pre; i++) begin
      tick();
      check("R2 armed waits, out_valid", int'(out_valid), 0);
    end
    set_trig(pat != 1, pat != 2);
    tc = cyc;
    tick();
    check("R7 no output in trigger cycle", int'(out_valid), 0);
    total = ph + tr;
    off = total / 2;
    elen = (len == 0) ? 1 : len;
    s0 = 2 * tc + total;
    dtag = (total % 2) ? "R5/R6 odd-start pair" : "R4/R6 even-start pair";
    last_k = off + elen + 5;
    for (int k = 1; k <= last_k; k++) begin
      // R9: further trigger edges during the wait/record/after it
      if (k == 1 || k == 2 || k == 4 || k == 5) set_trig(1'b1, 1'b1);
      else                                      set_trig(1'b0, 1'b0);
      tick();
      if (k >= off + 1 && k < off + 1 + elen) begin
        int idx;
        idx = k - (off + 1);
        check("R7/R8 out_valid in record", int'(out_valid), 1);
        check({dtag, " out_even"}, int'(out_even), int'(DW'(s0 + 2 * idx)));
        check({dtag, " out_odd"}, int'(out_odd), int'(DW'(s0 + 2 * idx + 1)));
        check("R8 out_first marker", int'(out_first), (idx == 0) ? 1 : 0);
      end else begin
        check("R7/R8/R9 out_valid outside record", int'(out_valid), 0);
      end
    end
    set_trig(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    set_trig(1'b1, 1'b1);
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_first after reset", int'(out_first), 0);
    arm = 1'b1; trim = '0; rec_len = LW'(2);
    tick();
    arm = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      check("R1 held-high trigger is no edge", int'(out_valid), 0);
    end
    set_trig(1'b0, 1'b0);
    tick();
  endtask

  task automatic t_no_rearm();
    for (int i = 0; i < 12; i++) begin
      set_trig(i % 3 == 1, i % 3 == 1);
      tick();
      check("R9 trigger without arm ignored", int'(out_valid), 0);
    end
    set_trig(1'b0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    run_capture(0, 0, 4, 2);    // R4 even start
    run_capture(1, 0, 4, 1);    // R5 odd start
    run_capture(2, 0, 3, 3);    // R3 even-only capture means even slot
    run_capture(0, 1, 3, 0);    // R6 trim moves to odd slot
    run_capture(1, 1, 5, 2);    // R6 odd + 1 -> even slot, one cycle later
    run_capture(1, 37, 5, 1);   // R6/R7 long trim
    run_capture(0, 63, 2, 0);   // R6 maximum trim
    run_capture(0, 4, 0, 2);    // R8 zero length gives one pair
    t_no_rearm();
    run_capture(1, 2, 6, 4);    // re-arm works after idle
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule